// File: doc/BRIEF.md
# Register-Mapped Serial Port With Handshake Lines

This block is an asynchronous serial port that a processor drives through a small register bus. Each direction has one holding register and no queue. A byte that arrives on the receive line lands in a data register and raises a ready flag. Reading that register lowers the flag. A byte written to the transmit register is handed to the output shifter as soon as the shifter is free, and the transmit-ready flag tells software when the holding register can take another byte.

Every condition flag has an enable bit at the same position in the control register. One interrupt line is the OR of the flags that are enabled. A compare register holds a packet-terminator character, and a flag rises whenever a received or transmitted byte equals it. The request-to-send output and the clear-to-send input are plain software signals: one bit of the control register drives the output, and a status bit shows the input. Neither line gates the serial engines.

The character is one start bit, eight data bits sent LSB first, no parity and two stop bits. One bit lasts 16*(divisor+1) clock cycles. The receiver takes its samples at mid-bit with a 16x oversampling count.

Top module: `sio_uart`

## Requirements
- R1: Register addresses are 0 receive data, 1 transmit data, 2 status, 3 control, 4 divisor and 5 terminator. After reset the status register reads 16'h0002 (only transmit-ready set), control reads 0, divisor reads DIV_RST (default 16), txd_o is 1, rts_o is 0 and irq_o is 0.
- R2: A valid frame on rxd_i puts its byte in the receive data register (bits 7:0) and sets status bit 0. A read strobe on address 0 clears status bit 0.
- R3: A write to address 1 while status bit 1 is set is accepted, and bit 1 clears until the byte moves into the shifter. The byte then leaves txd_o as a low start bit, eight data bits LSB first and two high stop bits. A write to address 1 while bit 1 is clear is ignored, and txd_o is 1 whenever no frame is in progress.
- R4: irq_o is 1 exactly when some status bit n in 0..4 and control bit n are both 1.
- R5: If a byte completes while status bit 0 is still set, status bit 2 (overrun) is set and the receive data register takes the new byte.
- R6: Status bit 3 is set when a received byte, or a byte moved into the transmit shifter, equals the terminator register bits 7:0.
- R7: Status bit 4 (framing error) is set when the first stop bit is sampled low.
- R8: Any write to the status register clears bits 2, 3 and 4 and leaves bit 0 unchanged.
- R9: Control bit 8 drives rts_o. Status bit 5 shows cts_i through a two-stage synchronizer. Neither line changes receive or transmit behaviour.
- R10: A low pulse on rxd_i shorter than half a bit is not taken as a start bit, and no byte results from it.
- R11: The bit period is 16*(divisor+1) clock cycles for both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects on receive data) |
| addr_i | input | 3 | Register address |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data of the addressed register, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_i | input | 1 | Clear-to-send input, software readable |
| rts_o | output | 1 | Request-to-send output, software driven |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sends a second byte before the first has been read. A design that drops the new byte or loses the overrun flag then fails, and so does one whose status write clears the receive-ready flag. It writes the transmit register three times in a row, so the third write arrives while the holding register is full. A design that overwrites the held byte or sends a third frame is caught by decoding the line. A half-bit glitch on the receive line and a frame with a low stop bit test start-bit rejection and framing detection. The frames use three divisor values and terminator bytes that do and do not match, which catches a wrong bit period or a wrong compare path in either direction.

// File: rtl/sio_uart_pkg.sv
package sio_uart_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EOP  = 3'd5;

  localparam int unsigned ST_RRDY = 0;
  localparam int unsigned ST_TRDY = 1;
  localparam int unsigned ST_OVR  = 2;
  localparam int unsigned ST_EOP  = 3;
  localparam int unsigned ST_FE   = 4;
  localparam int unsigned ST_CTS  = 5;
  localparam int unsigned IRQ_N   = 5;
  localparam int unsigned CTRL_RTS = 8;
  localparam int unsigned CTRL_W   = 9;

  localparam int unsigned OVS   = 16;
  localparam int unsigned OVS_W = $clog2(OVS);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq <= {STAGES{RST_VAL}};
    else         sq <= {sq[STAGES-2:0], d_i};
  end
  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  // >= keeps the counter sane when the divisor shrinks mid-count
  assign tick_o = (cnt_q >= div_i);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o
);
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS/2 - 1);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

  rx_state_e         st_q;
  logic [OVS_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= RX_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      done_o      <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (!rxd_i) begin
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: if (tick_i) begin
          if (cnt_q == MID) begin
            // line must still be low at mid start bit
            st_q  <= rxd_i ? RX_IDLE : RX_DATA;
            cnt_q <= '0;
            bit_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            sh_q <= {rxd_i, sh_q[DATA_W-1:1]};
            if (bit_q == BIT_W'(DATA_W - 1)) st_q <= RX_STOP;
            else                             bit_q <= bit_q + 1'b1;
          end
        end
        RX_STOP: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            done_o      <= 1'b1;
            frame_err_o <= !rxd_i;
            st_q        <= RX_IDLE;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
  assign data_o = sh_q;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_uart_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [LEFT_W-1:0]  left_q;
  logic [OVS_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      busy_o  <= 1'b0;
    end else if (load_i) begin
      frame_q <= {{STOP_BITS{1'b1}}, data_i, 1'b0};
      left_q  <= LEFT_W'(FRAME_W);
      cnt_q   <= '0;
      busy_o  <= 1'b1;
    end else if (busy_o && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == LEFT_W'(1)) busy_o <= 1'b0;
      end
    end
  end
  assign txd_o = busy_o ? frame_q[0] : 1'b1;
endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_uart_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STOP_BITS = 2,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned BUS_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              cts_i,
  output logic              rts_o,
  output logic              irq_o
);
  logic rxd_s, cts_s, tick;
  logic rx_done, rx_fe, tx_busy, tx_load;
  logic [DATA_W-1:0] rx_byte;

  logic [DIV_W-1:0]  div_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] eop_q, rx_data_q, hold_data_q;
  logic hold_q, rx_rdy_q, ovr_q, fe_q, match_q;
  logic [BUS_W-1:0] stat;

  logic rxd_rd, txd_wr, stat_wr, ctrl_wr, div_wr, eop_wr, tx_rdy, hit;

  assign rxd_rd  = rd_i && (addr_i == A_RXD);
  assign txd_wr  = wr_i && (addr_i == A_TXD);
  assign stat_wr = wr_i && (addr_i == A_STAT);
  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign div_wr  = wr_i && (addr_i == A_DIV);
  assign eop_wr  = wr_i && (addr_i == A_EOP);

  sio_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s));
  sio_sync #(.STAGES(2), .RST_VAL(1'b0)) u_cts_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_i), .q_o(cts_s));

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q), .tick_o(tick));

  sio_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_s),
    .done_o(rx_done), .data_o(rx_byte), .frame_err_o(rx_fe));

  assign tx_rdy  = !hold_q;
  assign tx_load = hold_q && !tx_busy;

  sio_tx #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(tx_load),
    .data_i(hold_data_q), .busy_o(tx_busy), .txd_o(txd_o));

  assign hit = (rx_done && (rx_byte == eop_q)) || (tx_load && (hold_data_q == eop_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= DIV_RST;
      ctrl_q      <= '0;
      eop_q       <= '0;
      rx_data_q   <= '0;
      hold_data_q <= '0;
      hold_q      <= 1'b0;
      rx_rdy_q    <= 1'b0;
      ovr_q       <= 1'b0;
      fe_q        <= 1'b0;
      match_q     <= 1'b0;
    end else begin
      if (div_wr)  div_q  <= wdata_i[DIV_W-1:0];
      if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (eop_wr)  eop_q  <= wdata_i[DATA_W-1:0];

      if (txd_wr && !hold_q) begin
        hold_q      <= 1'b1;
        hold_data_q <= wdata_i[DATA_W-1:0];
      end else if (tx_load) begin
        hold_q <= 1'b0;
      end

      if (rx_done) begin
        rx_data_q <= rx_byte;
        rx_rdy_q  <= 1'b1;
      end else if (rxd_rd) begin
        rx_rdy_q <= 1'b0;
      end

      // set beats clear when both happen in one cycle
      if (rx_done && rx_rdy_q)  ovr_q   <= 1'b1;
      else if (stat_wr)         ovr_q   <= 1'b0;
      if (rx_done && rx_fe)     fe_q    <= 1'b1;
      else if (stat_wr)         fe_q    <= 1'b0;
      if (hit)                  match_q <= 1'b1;
      else if (stat_wr)         match_q <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_RRDY] = rx_rdy_q;
    stat[ST_TRDY] = tx_rdy;
    stat[ST_OVR]  = ovr_q;
    stat[ST_EOP]  = match_q;
    stat[ST_FE]   = fe_q;
    stat[ST_CTS]  = cts_s;
  end

  assign irq_o = |(stat[IRQ_N-1:0] & ctrl_q[IRQ_N-1:0]);
  assign rts_o = ctrl_q[CTRL_RTS];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_RXD:   rdata_o[DATA_W-1:0] = rx_data_q;
      A_STAT:  rdata_o = stat;
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      A_DIV:   rdata_o[DIV_W-1:0]  = div_q;
      A_EOP:   rdata_o[DATA_W-1:0] = eop_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk
  import sio_uart_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rxd_rd,
  input logic              txd_wr,
  input logic              stat_wr,
  input logic              rx_done,
  input logic              rx_rdy_q,
  input logic              tx_rdy,
  input logic              tx_load,
  input logic              tx_busy,
  input logic              ovr_q,
  input logic              fe_q,
  input logic              match_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              irq_o,
  input logic              txd_o
);
  AST_RRDY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxd_rd && !rx_done |=> !rx_rdy_q); // R2
  AST_TX_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_wr && tx_rdy |=> !tx_rdy); // R3
  AST_TX_HOLD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_rdy && !tx_load |=> !tx_rdy); // R3
  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[IRQ_N-1:0] == '0 |-> !irq_o); // R4
  AST_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && rx_rdy_q |=> ovr_q); // R5
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && !rx_done && !tx_load |=> !ovr_q && !fe_q && !match_q); // R8
  AST_STAT_KEEP_RRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && !rxd_rd && rx_rdy_q |=> rx_rdy_q); // R8
endmodule

bind sio_uart sio_uart_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rxd_rd(rxd_rd), .txd_wr(txd_wr),
  .stat_wr(stat_wr), .rx_done(rx_done), .rx_rdy_q(rx_rdy_q), .tx_rdy(tx_rdy),
  .tx_load(tx_load), .tx_busy(tx_busy), .ovr_q(ovr_q), .fe_q(fe_q),
  .match_q(match_q), .ctrl_q(ctrl_q), .irq_o(irq_o), .txd_o(txd_o));

// File: tb/sio_uart_tb.sv
`timescale 1ns/1ps
module sio_uart_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rxd = 1'b1, cts = 1'b0;
  logic txd, rts, irq;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sio_uart u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
    .cts_i(cts), .rts_o(rts), .irq_o(irq));

  // {divisor, byte, terminator}
  localparam logic [23:0] VEC [0:3] = '{
    {8'd0, 8'hA5, 8'h00},
    {8'd1, 8'h3C, 8'h3C},
    {8'd2, 8'h01, 8'hFF},
    {8'd0, 8'hFF, 8'hFF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input int bitc, input logic stop0);
    @(negedge clk); rxd = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bitc) @(negedge clk);
    end
    rxd = stop0;
    repeat (bitc) @(negedge clk);
    rxd = 1'b1;
    repeat (bitc) @(negedge clk);
  endtask

  task automatic get_tx(input int bitc, output logic [7:0] b, output logic [1:0] stops);
    int t = 0;
    while (txd && t < 5000) begin @(negedge clk); t++; end
    repeat (bitc/2) @(negedge clk);
    chk("R3 start bit", {15'd0, txd}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (bitc) @(negedge clk);
      b[i] = txd;
    end
    repeat (bitc) @(negedge clk); stops[0] = txd;
    repeat (bitc) @(negedge clk); stops[1] = txd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s, d;
    logic [7:0] tb0, tb1;
    logic [1:0] st0, st1;
    bit seen_low;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 txd", {15'd0, txd}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rts", {15'd0, rts}, 16'd0);
    bus_rd(3'd2, s); chk("R1 status", s, 16'h0002);
    bus_rd(3'd3, s); chk("R1 control", s, 16'h0000);
    bus_rd(3'd4, s); chk("R1 divisor", s, 16'd16);

    // R10 short glitch rejected
    bus_wr(3'd4, 16'd0);
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (300) @(negedge clk);
    bus_rd(3'd2, s); chk("R10 no byte after glitch", {15'd0, s[0]}, 16'd0);

    // table: receive then transmit each byte (R2 R3 R6 R11)
    for (int v = 0; v < 4; v++) begin
      logic [7:0] dv, bv, ev;
      int bitc;
      {dv, bv, ev} = VEC[v];
      bitc = 16 * (int'(dv) + 1);
      bus_wr(3'd4, {8'd0, dv});
      bus_wr(3'd5, {8'd0, ev});
      bus_wr(3'd2, 16'd0);
      send_rx(bv, bitc, 1'b1);
      repeat (4) @(negedge clk);
      bus_rd(3'd2, s);
      chk("R2 rx ready", {15'd0, s[0]}, 16'd1);
      chk("R6 rx match", {15'd0, s[3]}, {15'd0, bv == ev});
      chk("R7 no framing error", {15'd0, s[4]}, 16'd0);
      bus_rd(3'd0, d); chk("R11 rx byte", d, {8'd0, bv});
      bus_rd(3'd2, s); chk("R2 ready cleared by read", {15'd0, s[0]}, 16'd0);
      bus_wr(3'd2, 16'd0);
      bus_wr(3'd1, {8'd0, bv});
      get_tx(bitc, tb0, st0);
      chk("R11 tx byte", {8'd0, tb0}, {8'd0, bv});
      chk("R3 stop bits", {14'd0, st0}, 16'd3);
      bus_rd(3'd2, s); chk("R6 tx match", {15'd0, s[3]}, {15'd0, bv == ev});
    end

    // R5 overrun, R4 masking, R8 status clear
    bus_wr(3'd4, 16'd0);
    bus_wr(3'd5, 16'h00EE);
    bus_wr(3'd2, 16'd0);
    send_rx(8'h11, 16, 1'b1);
    send_rx(8'h22, 16, 1'b1);
    repeat (4) @(negedge clk);
    bus_rd(3'd2, s);
    chk("R5 overrun flag", {15'd0, s[2]}, 16'd1);
    chk("R5 ready still set", {15'd0, s[0]}, 16'd1);
    bus_wr(3'd3, 16'h0004); @(negedge clk);
    chk("R4 irq on enabled overrun", {15'd0, irq}, 16'd1);
    bus_wr(3'd3, 16'h0008); @(negedge clk);
    chk("R4 irq masked", {15'd0, irq}, 16'd0);
    bus_wr(3'd3, 16'h0000);
    bus_wr(3'd2, 16'hFFFF);
    bus_rd(3'd2, s);
    chk("R8 overrun cleared", {15'd0, s[2]}, 16'd0);
    chk("R8 ready kept", {15'd0, s[0]}, 16'd1);
    bus_rd(3'd0, d); chk("R5 newest byte kept", d, 16'h0022);

    // R7 framing error
    send_rx(8'h5A, 16, 1'b0);
    repeat (4) @(negedge clk);
    bus_rd(3'd2, s); chk("R7 framing flag", {15'd0, s[4]}, 16'd1);
    bus_wr(3'd3, 16'h0010); @(negedge clk);
    chk("R4 irq on framing", {15'd0, irq}, 16'd1);
    bus_wr(3'd3, 16'h0002); @(negedge clk);
    chk("R4 irq on tx ready", {15'd0, irq}, 16'd1);
    bus_wr(3'd3, 16'h0000);
    bus_rd(3'd0, d);
    bus_wr(3'd2, 16'd0);

    // R3 back-to-back writes: third write ignored
    fork
      begin
        get_tx(16, tb0, st0);
        get_tx(16, tb1, st1);
      end
      begin
        bus_wr(3'd1, 16'h0081);
        bus_wr(3'd1, 16'h0042);
        bus_rd(3'd2, s);
        bus_wr(3'd1, 16'h0099);
      end
    join
    chk("R3 tx ready low while held", {15'd0, s[1]}, 16'd0);
    chk("R3 first frame", {8'd0, tb0}, 16'h0081);
    chk("R3 second frame", {8'd0, tb1}, 16'h0042);
    seen_low = 1'b0;
    repeat (400) begin @(negedge clk); if (!txd) seen_low = 1'b1; end
    chk("R3 ignored write sent nothing", {15'd0, seen_low}, 16'd0);

    // R9 handshake lines
    bus_wr(3'd3, 16'h0100); @(negedge clk);
    chk("R9 rts driven", {15'd0, rts}, 16'd1);
    cts = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(3'd2, s);
    chk("R9 cts visible", {15'd0, s[5]}, 16'd1);
    chk("R9 no rx effect", {15'd0, s[0]}, 16'd0);
    chk("R9 no tx effect", {15'd0, txd}, 16'd1);
    cts = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(3'd2, s); chk("R9 cts low", {15'd0, s[5]}, 16'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule